// File: doc/BRIEF.md
# Token Link Sleep/Wake Controller

This block decides whether a single-wire token interface is awake or asleep. A separate front end decodes the line and hands it strobes: a wake token, the leading edge of a data token, the end of a received command (with a flag telling whether that command was well formed), and transmit-token requests. The controller answers with a registered sleep level and a one-cycle status pulse that carries the reply code 0x11.

Two timers can put the link back to sleep. The inter-token timer expires when the host stops sending tokens. It is paused while a command is being parsed and executed. It restarts only when a transmit token arrives after the command's processing window, and that window is longer for a good command than for a bad one. The watchdog starts on wake and cannot be cleared by anything except a sleep followed by a new wake. When it expires, the block goes to sleep whatever else is happening in that cycle. Every delay is a parameter counted in clock cycles. A reply byte goes on the wire least significant bit first; that serialisation belongs to the front end.

Top module: `tok_power_ctrl`

## Requirements
- R1: While reset is low and after it is released, `asleep` is 1 and `status_valid` is 0.
- R2: A `wake_tok` sampled while asleep drives `asleep` to 0 one clock later.
- R3: While idle-awake, `asleep` rises T_TIMEOUT cycles after the wake sample, or after the last sampled `tok_edge`. A `tok_edge` sampled exactly T_TIMEOUT cycles after the previous one still keeps the link awake.
- R4: After `cmd_done` is sampled, the inter-token timer is stopped. No timeout sleep occurs while waiting for the transmit token, however long that wait is.
- R5: When `cmd_done` is sampled with `cmd_good`=1, every `tx_req` in the following T_PARSE+T_EXEC cycles is ignored. The first `tx_req` after that window is accepted and restarts the inter-token timer.
- R6: When `cmd_done` is sampled with `cmd_good`=0, the same rule applies with a window of T_PARSE cycles.
- R7: `asleep` rises exactly T_WATCHDOG cycles after the wake sample, whatever token or command activity takes place in between.
- R8: A `wake_tok` sampled while awake has no effect and does not restart the watchdog.
- R9: In the cycle the watchdog expires, sleep wins: a `tx_req` sampled in that cycle gives no status pulse.
- R10: The first accepted `tx_req` after each wake raises `status_valid` for exactly one cycle, one clock later, with `status_byte`=0x11. Later `tx_req`s before the next wake give no pulse, and `status_byte` is 0 when `status_valid` is 0.
- R11: While asleep, `tok_edge`, `cmd_done`, `cmd_good` and `tx_req` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wake_tok | input | 1 | Wake token seen (strobe) |
| tok_edge | input | 1 | Leading edge of a data token (strobe) |
| cmd_done | input | 1 | Last bit of a command received (strobe) |
| cmd_good | input | 1 | Command well formed; qualifies `cmd_done` |
| tx_req | input | 1 | Transmit token from the host (strobe) |
| asleep | output | 1 | Registered sleep level |
| status_valid | output | 1 | One-cycle reply pulse |
| status_byte | output | 8 | Reply code 0x11 while `status_valid`, else 0 |

## Verification
Every strobe is sampled on a rising edge, and every result is visible right after that edge. A wake therefore clears `asleep` one cycle later. A timeout or watchdog expiry sets `asleep` exactly T_TIMEOUT or T_WATCHDOG cycles after the sample that started the timer. A status pulse appears in the cycle after the `tx_req` sample. The bench drives and reads on falling edges and counts falling edges from each stimulus. It checks each deadline on both sides: still awake one cycle before, asleep on the cycle itself. For the command window, it holds `tx_req` high and requires the pulse on exactly window+1 cycles.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  typedef enum logic [1:0] {
    ST_SLEEP   = 2'd0,
    ST_IDLE    = 2'd1,
    ST_BUSY    = 2'd2,
    ST_WAIT_TX = 2'd3
  } pwr_state_t;

  localparam logic [7:0] REPLY_CODE = 8'h11;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // cycles during which transmit tokens are ignored after a command ends
  function automatic int gate_len(input logic good, input int parse_c, input int exec_c);
    return good ? (parse_c + exec_c) : parse_c;
  endfunction

endpackage

// File: rtl/tpc_up_timer.sv
module tpc_up_timer #(
  parameter int CW    = 8,
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic hit
);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt <= '0;
    else if (clr)                  cnt <= '0;
    else if (run && cnt != LAST)   cnt <= cnt + 1'b1;
  end

  assign hit = run && !clr && (cnt == LAST);

  // R3 / R7: count never passes its expiry value
  a_r7_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R3: a clear always wins over an expiry
  a_r3_clear_resets: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !hit || (LIMIT == 1));

endmodule

// File: rtl/tpc_gate_timer.sv
module tpc_gate_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len,
  input  logic          run,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= len;
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = run && (cnt == {{(CW-1){1'b0}}, 1'b1});

  // R5 / R6: the window is never left open past its end
  a_r5_gate_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt != '0);

endmodule

// File: rtl/tok_power_ctrl.sv
module tok_power_ctrl
  import tpc_pkg::*;
#(
  parameter int T_TIMEOUT  = 20,
  parameter int T_PARSE    = 6,
  parameter int T_EXEC     = 10,
  parameter int T_WATCHDOG = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wake_tok,
  input  logic       tok_edge,
  input  logic       cmd_done,
  input  logic       cmd_good,
  input  logic       tx_req,
  output logic       asleep,
  output logic       status_valid,
  output logic [7:0] status_byte
);
  localparam int MAXT = max3(T_TIMEOUT, T_PARSE + T_EXEC, T_WATCHDOG);
  localparam int CW   = $clog2(MAXT + 1);

  pwr_state_t state_q, state_d;
  logic       asleep_q, valid_q, pending_q;

  // named internal events
  logic in_sleep, in_idle, in_busy, in_wait;
  logic wake_acc, tx_acc, tx_fire, go_sleep;
  logic io_clr, io_hit, wd_hit, gate_load, gate_done;
  logic [CW-1:0] gate_val;

  assign in_sleep = (state_q == ST_SLEEP);
  assign in_idle  = (state_q == ST_IDLE);
  assign in_busy  = (state_q == ST_BUSY);
  assign in_wait  = (state_q == ST_WAIT_TX);

  assign wake_acc  = in_sleep && wake_tok;
  assign tx_acc    = in_wait && tx_req;
  assign go_sleep  = wd_hit || (in_idle && io_hit);
  assign tx_fire   = pending_q && tx_req && (in_idle || in_wait) && !go_sleep;
  assign io_clr    = wake_acc || (in_idle && tok_edge) || tx_acc;
  assign gate_load = in_idle && cmd_done;
  assign gate_val  = CW'(gate_len(cmd_good, T_PARSE, T_EXEC));

  tpc_up_timer #(.CW(CW), .LIMIT(T_TIMEOUT)) u_io_timer (
    .clk(clk), .rst_n(rst_n), .clr(io_clr), .run(in_idle), .hit(io_hit)
  );

  tpc_up_timer #(.CW(CW), .LIMIT(T_WATCHDOG)) u_watchdog (
    .clk(clk), .rst_n(rst_n), .clr(wake_acc), .run(!in_sleep), .hit(wd_hit)
  );

  tpc_gate_timer #(.CW(CW)) u_gate (
    .clk(clk), .rst_n(rst_n), .load(gate_load), .len(gate_val),
    .run(in_busy), .done(gate_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_SLEEP:   if (wake_tok) state_d = ST_IDLE;
      ST_IDLE: begin
        if (io_hit)        state_d = ST_SLEEP;
        else if (cmd_done) state_d = ST_BUSY;
      end
      ST_BUSY:    if (gate_done) state_d = ST_WAIT_TX;
      ST_WAIT_TX: if (tx_req)    state_d = ST_IDLE;
      default:    state_d = ST_SLEEP;
    endcase
    if (wd_hit) state_d = ST_SLEEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_SLEEP;
      asleep_q  <= 1'b1;
      valid_q   <= 1'b0;
      pending_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      asleep_q <= (state_d == ST_SLEEP);
      valid_q  <= tx_fire;
      if (wake_acc)     pending_q <= 1'b1;
      else if (tx_fire) pending_q <= 1'b0;
    end
  end

  assign asleep       = asleep_q;
  assign status_valid = valid_q;
  assign status_byte  = valid_q ? REPLY_CODE : 8'h00;

  // R1: reset leaves the link asleep and quiet
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> asleep && !status_valid);

  // R2: a wake while asleep opens the link one clock later
  a_r2_wake_opens: assert property (@(posedge clk) disable iff (!rst_n)
    asleep && wake_tok |=> !asleep);

  // R3: inter-token expiry closes the link
  a_r3_timeout_sleeps: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle && io_hit |=> asleep);

  // R4: no timeout while parsing, executing or awaiting transmit
  a_r4_no_io_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_busy || in_wait) && !wd_hit |=> !asleep);

  // R9: watchdog expiry beats every other event
  a_r9_wd_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wd_hit |=> asleep && !status_valid);

  // R10: the reply pulse lasts one cycle and only while awake
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |=> !status_valid);
  a_r10_pulse_awake: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |-> !asleep);

  // R11: only a wake leaves sleep
  a_r11_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
    asleep && !wake_tok |=> asleep && !status_valid);

endmodule

// File: tb/tok_power_ctrl_test.sv
module tok_power_ctrl_test;
  localparam int TT = 20;
  localparam int TP = 6;
  localparam int TE = 10;
  localparam int TW = 400;

  logic clk = 1'b0;
  logic rst_n, wake_tok, tok_edge, cmd_done, cmd_good, tx_req;
  logic asleep, status_valid;
  logic [7:0] status_byte;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  tok_power_ctrl #(.T_TIMEOUT(TT), .T_PARSE(TP), .T_EXEC(TE), .T_WATCHDOG(TW)) uut (
    .clk(clk), .rst_n(rst_n), .wake_tok(wake_tok), .tok_edge(tok_edge),
    .cmd_done(cmd_done), .cmd_good(cmd_good), .tx_req(tx_req),
    .asleep(asleep), .status_valid(status_valid), .status_byte(status_byte)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_wake();
    wake_tok = 1'b1; tick(1); wake_tok = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wake_tok = 0; tok_edge = 0; cmd_done = 0; cmd_good = 0; tx_req = 0;
    tick(3);
    chk("R1 asleep in reset", asleep, 1);
    rst_n = 1'b1; tick(1);
    chk("R1 asleep after reset", asleep, 1);
    chk("R1 no pulse after reset", status_valid, 0);
  endtask

  task automatic t_wake_timeout();
    do_wake();
    chk("R2 awake one clock after wake", asleep, 0);
    tick(TT - 1);
    chk("R3 awake before timeout", asleep, 0);
    tick(1);
    chk("R3 asleep at timeout", asleep, 1);
  endtask

  task automatic t_edge_rescue();
    do_wake();
    tick(TT - 1);
    tok_edge = 1'b1; tick(1); tok_edge = 1'b0;
    chk("R3 edge on last cycle keeps awake", asleep, 0);
    tick(TT - 1);
    chk("R3 awake before second timeout", asleep, 0);
    tick(1);
    chk("R3 asleep after second timeout", asleep, 1);
  endtask

  task automatic t_cmd_gate(input logic good);
    int d;
    int n;
    string tag;
    tag = good ? "R5" : "R6";
    d = good ? (TP + TE) : TP;
    do_wake();
    cmd_good = good; cmd_done = 1'b1; tick(1); cmd_done = 1'b0; cmd_good = 1'b0;
    tx_req = 1'b1;
    n = 0;
    for (int i = 0; i < d + 5; i++) begin
      tick(1);
      n++;
      if (status_valid) break;
    end
    chk({tag, " first accepted tx after window"}, n, d + 1);
    chk("R10 reply code", status_byte, 8'h11);
    tx_req = 1'b0;
    tick(1);
    chk("R10 pulse is one cycle", status_valid, 0);
    chk("R10 byte zero when idle", status_byte, 0);
    tx_req = 1'b1; tick(1); tx_req = 1'b0;
    chk("R10 second tx gives no pulse", status_valid, 0);
    tick(TT - 3);
    chk({tag, " timer re-armed, still awake"}, asleep, 0);
    tick(1);
    chk({tag, " timer re-armed, expires"}, asleep, 1);
  endtask

  task automatic t_no_io_in_busy();
    do_wake();
    cmd_good = 1'b1; cmd_done = 1'b1; tick(1); cmd_done = 1'b0; cmd_good = 1'b0;
    tick(TP + TE + 2 * TT);
    chk("R4 no timeout awaiting tx", asleep, 0);
    tx_req = 1'b1; tick(1); tx_req = 1'b0;
    chk("R4 late tx accepted", status_valid, 1);
    tick(TT);
    chk("R4 timer runs again after tx", asleep, 1);
  endtask

  task automatic t_watchdog();
    do_wake();
    tok_edge = 1'b1;
    tick(50);
    wake_tok = 1'b1; tick(1); wake_tok = 1'b0;
    tick(TW - 52);
    chk("R7 awake just before watchdog", asleep, 0);
    tx_req = 1'b1; tick(1); tx_req = 1'b0;
    chk("R8 R7 asleep at watchdog expiry", asleep, 1);
    chk("R9 no pulse on expiry cycle", status_valid, 0);
    tok_edge = 1'b0;
  endtask

  task automatic t_sleep_ignores();
    tok_edge = 1; cmd_done = 1; cmd_good = 1; tx_req = 1;
    tick(5);
    chk("R11 stays asleep", asleep, 1);
    chk("R11 no pulse while asleep", status_valid, 0);
    tok_edge = 0; cmd_done = 0; cmd_good = 0; tx_req = 0;
    do_wake();
    tx_req = 1'b1; tick(1); tx_req = 1'b0;
    chk("R10 pulse after re-wake", status_valid, 1);
    tick(TT - 2);
    chk("R11 awake before timeout", asleep, 0);
    tick(1);
    chk("R3 tx in idle does not rearm", asleep, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_wake_timeout();
    t_edge_rescue();
    t_cmd_gate(1'b1);
    t_cmd_gate(1'b0);
    t_no_io_in_busy();
    t_watchdog();
    t_sleep_ignores();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule